// File: doc/BRIEF.md
# Interrupt Pin Service Engine

This block sits behind a set of external interrupt lines and decides when each line turns into a delivery request toward the processor-side interrupt controller. Every line has its own programmed entry: a mask, an input polarity, a trigger mode (edge or level), a vector number and a destination with a physical/logical mode flag. The block keeps a per-line request bit and a per-line service state machine. It emits at most one delivery per cycle, carrying the pin index, vector, destination and destination mode.

Level-triggered lines are gated by a remote-pending flag. The flag is set when a delivery for that line leaves the block and is cleared only by an end-of-interrupt notice carrying the same vector. The notice is compared against every entry at once, so all lines sharing that vector are released together. A level line that is still active when it is released goes straight back into the delivery queue. A new activation that cannot be serviced because the line is already queued or awaiting its end-of-interrupt is flagged as coalesced for one cycle. Line 0 is always routed in physical mode to a fixed bootstrap destination.

Each line runs a three-state machine. IDLE means nothing is outstanding. QUEUED means a service was accepted and is waiting for the lowest-index arbiter. INSVC means a level delivery went out and the line waits for its end-of-interrupt. The transitions are:
- take: IDLE to QUEUED on a service event while unmasked. A service event is a 0-to-1 change of the request bit in edge mode, or an active request bit in level mode.
- grant_edge: QUEUED to IDLE when granted in edge mode.
- grant_level: QUEUED to INSVC when granted in level mode.
- drop: QUEUED to IDLE when the entry becomes masked before it is granted.
- release: INSVC to IDLE on a matching end-of-interrupt when the line is inactive or masked.
- reissue: INSVC to QUEUED on a matching end-of-interrupt when the line is unmasked and still active.

Top module: `irq_pin_service`

## Requirements
- R1: The effective level of a line is `pin_raw[i] ^ cfg_pol[i]`, with 1 meaning active. The request bit tracks the effective level: an inactive level clears it and an active level sets it.
- R2: An unmasked edge-mode line yields exactly one delivery for each 0-to-1 change of its effective level. Holding the level active yields no further deliveries.
- R3: An unmasked level-mode line with remote-pending clear yields a delivery while its effective level is active. `remote_pend[i]` rises in the same cycle that this delivery appears on the outputs.
- R4: While a line is QUEUED or INSVC, a fresh 0-to-1 change of its effective level yields no extra delivery. `coalesced[i]` is 1 for exactly one cycle, the cycle after the clock edge that saw the change.
- R5: Servicing a masked entry produces no delivery, no remote-pending flag and no coalesced flag.
- R6: An end-of-interrupt (`eoi_valid`=1) whose `eoi_vec` equals an INSVC entry's vector clears that entry's remote-pending flag. This applies to all matching entries in the same cycle. Each released entry that is unmasked and still active is delivered again.
- R7: An end-of-interrupt whose vector matches no INSVC entry changes no remote-pending flag and causes no delivery.
- R8: A delivery from line 0 always carries `dlv_dest` = BSP_DEST and `dlv_logical` = 0 (physical), whatever its programmed destination. Other lines carry their programmed destination and mode.
- R9: When several lines are QUEUED, the lowest index is delivered first, one line per cycle. The same line is never delivered in two consecutive cycles.
- R10: After reset all outputs are 0. An activation seen at clock edge k appears as `dlv_valid` = 1 just after edge k+1, with `dlv_pin`, `dlv_vec`, `dlv_dest` and `dlv_logical` valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_raw | input | NPINS | Raw interrupt line levels |
| cfg_mask | input | NPINS | Per-line mask, 1 = masked |
| cfg_pol | input | NPINS | Per-line polarity, 1 = active low |
| cfg_level | input | NPINS | Trigger mode, 1 = level, 0 = edge |
| cfg_logical | input | NPINS | Destination mode, 1 = logical |
| cfg_vec | input | NPINS*VEC_W | Vector per line, line i at bits i*VEC_W |
| cfg_dest | input | NPINS*DEST_W | Destination per line, line i at bits i*DEST_W |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | VEC_W | Vector carried by the end-of-interrupt |
| dlv_valid | output | 1 | Delivery request this cycle |
| dlv_pin | output | $clog2(NPINS) | Index of the delivered line |
| dlv_vec | output | VEC_W | Vector of the delivery |
| dlv_dest | output | DEST_W | Destination of the delivery |
| dlv_logical | output | 1 | Destination mode of the delivery |
| coalesced | output | NPINS | One-cycle flag per line for a merged activation |
| remote_pend | output | NPINS | Per-line remote-pending status |

## Verification
Every line is swept through an edge activation under both polarities. This separates a correct polarity XOR from a missing one, and it shows the line-0 route override apart from the programmed routing of the other lines. A held level line, a dropped and re-raised level line, and matching and non-matching end-of-interrupts separate gating by remote-pending from plain level following, and they show re-issue on release apart from a simple flag clear. Two level lines sharing one vector show that release happens across entries. Raising all lines at once, and toggling the last line while it waits, shows the lowest-first order and the edge-mode coalesce report.

// File: rtl/irq_svc_pkg.sv
package irq_svc_pkg;

    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_QUEUED = 2'd1,
        PS_INSVC  = 2'd2
    } pin_state_e;

endpackage

// File: rtl/irq_pin_fsm.sv
module irq_pin_fsm
    import irq_svc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic             pol,
    input  logic             mask,
    input  logic             level_mode,
    input  logic [VEC_W-1:0] vec,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vec,
    input  logic             grant,
    output logic             queued,
    output logic             insvc,
    output logic             coal_evt
);

    pin_state_e st, st_nxt;
    logic       req_q;
    logic       eff;
    logic       rise;
    logic       eoi_hit;
    logic       svc_evt;

    // effective level and request bit (R1)
    assign eff     = raw ^ pol;
    assign rise    = eff & ~req_q;
    assign eoi_hit = eoi_valid && (eoi_vec == vec);
    // in IDLE the remote-pending flag is clear, so level mode is gated by eff only
    assign svc_evt = level_mode ? eff : rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= PS_IDLE;
            req_q <= 1'b0;
        end else begin
            st    <= st_nxt;
            req_q <= eff;
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            PS_IDLE: begin
                if (svc_evt && !mask) st_nxt = PS_QUEUED;          // take
            end
            PS_QUEUED: begin
                if (grant)     st_nxt = level_mode ? PS_INSVC : PS_IDLE; // grant_level / grant_edge
                else if (mask) st_nxt = PS_IDLE;                   // drop
            end
            PS_INSVC: begin
                if (eoi_hit) st_nxt = (!mask && eff) ? PS_QUEUED : PS_IDLE; // reissue / release
            end
            default: st_nxt = PS_IDLE;
        endcase
    end

    always_comb begin
        queued   = (st == PS_QUEUED);
        insvc    = (st == PS_INSVC);
        coal_evt = rise && (st != PS_IDLE) && !(st == PS_INSVC && eoi_hit);
    end

    // R5: a masked idle line never enters the queue
    assert_masked_no_queue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_IDLE && mask) |=> (st != PS_QUEUED));

    // R6: remote-pending only ends through a matching end-of-interrupt
    assert_release_by_eoi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(insvc) |-> ($past(eoi_valid) && ($past(eoi_vec) == $past(vec))));

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0]         req,
    output logic [N-1:0]         grant,
    output logic [$clog2(N)-1:0] idx
);

    localparam int IW = $clog2(N);

    // scan from the top down so the lowest active index is written last
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant = N'(1) << i;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_pin_service.sv
module irq_pin_service #(
    parameter int NPINS    = 4,
    parameter int VEC_W    = 8,
    parameter int DEST_W   = 8,
    parameter int BSP_DEST = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPINS-1:0]          pin_raw,
    input  logic [NPINS-1:0]          cfg_mask,
    input  logic [NPINS-1:0]          cfg_pol,
    input  logic [NPINS-1:0]          cfg_level,
    input  logic [NPINS-1:0]          cfg_logical,
    input  logic [NPINS*VEC_W-1:0]    cfg_vec,
    input  logic [NPINS*DEST_W-1:0]   cfg_dest,
    input  logic                      eoi_valid,
    input  logic [VEC_W-1:0]          eoi_vec,
    output logic                      dlv_valid,
    output logic [$clog2(NPINS)-1:0]  dlv_pin,
    output logic [VEC_W-1:0]          dlv_vec,
    output logic [DEST_W-1:0]         dlv_dest,
    output logic                      dlv_logical,
    output logic [NPINS-1:0]          coalesced,
    output logic [NPINS-1:0]          remote_pend
);

    localparam int PIN_W = $clog2(NPINS);
    localparam logic [DEST_W-1:0] BOOT_DEST = DEST_W'(BSP_DEST);

    logic [NPINS-1:0] queued;
    logic [NPINS-1:0] insvc;
    logic [NPINS-1:0] coal_evt;
    logic [NPINS-1:0] grant;
    logic [PIN_W-1:0] gidx;

    logic [VEC_W-1:0]  sel_vec;
    logic [DEST_W-1:0] sel_dest;
    logic              sel_logical;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        irq_pin_fsm #(.VEC_W(VEC_W)) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .raw        (pin_raw[g]),
            .pol        (cfg_pol[g]),
            .mask       (cfg_mask[g]),
            .level_mode (cfg_level[g]),
            .vec        (cfg_vec[g*VEC_W +: VEC_W]),
            .eoi_valid  (eoi_valid),
            .eoi_vec    (eoi_vec),
            .grant      (grant[g]),
            .queued     (queued[g]),
            .insvc      (insvc[g]),
            .coal_evt   (coal_evt[g])
        );
    end

    irq_pick #(.N(NPINS)) u_pick (
        .req   (queued),
        .grant (grant),
        .idx   (gidx)
    );

    // payload of the granted line, with the line-0 routing override (R8)
    always_comb begin
        sel_vec     = cfg_vec[gidx*VEC_W +: VEC_W];
        sel_dest    = cfg_dest[gidx*DEST_W +: DEST_W];
        sel_logical = cfg_logical[gidx];
        if (gidx == '0) begin
            sel_dest    = BOOT_DEST;
            sel_logical = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlv_valid   <= 1'b0;
            dlv_pin     <= '0;
            dlv_vec     <= '0;
            dlv_dest    <= '0;
            dlv_logical <= 1'b0;
            coalesced   <= '0;
        end else begin
            dlv_valid   <= |grant;
            dlv_pin     <= gidx;
            dlv_vec     <= sel_vec;
            dlv_dest    <= sel_dest;
            dlv_logical <= sel_logical;
            coalesced   <= coal_evt;
        end
    end

    assign remote_pend = insvc;

    // R9: the arbiter grants at most one line per cycle
    assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R9: the same line is never delivered on two consecutive cycles
    assert_no_repeat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |=> !(dlv_valid && (dlv_pin == $past(dlv_pin))));

    // R8: line 0 leaves in physical mode toward the bootstrap destination
    assert_pin0_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_pin == '0) |-> (dlv_dest == BOOT_DEST && !dlv_logical));

    for (genvar g = 0; g < NPINS; g++) begin : g_chk
        // R3: remote-pending rises together with that line's delivery
        assert_remote_with_dlv_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(remote_pend[g]) |-> (dlv_valid && dlv_pin == PIN_W'(g)));
    end

endmodule

// File: tb/tb_irq_pin_service.sv
`timescale 1ns/1ps
module tb_irq_pin_service;

    localparam int NP = 4;
    localparam int VW = 8;
    localparam int DW = 8;
    localparam int BSP = 8'h5A;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NP-1:0]     pin_raw;
    logic [NP-1:0]     cfg_mask, cfg_pol, cfg_level, cfg_logical;
    logic [NP*VW-1:0]  cfg_vec;
    logic [NP*DW-1:0]  cfg_dest;
    logic              eoi_valid;
    logic [VW-1:0]     eoi_vec;
    logic              dlv_valid;
    logic [1:0]        dlv_pin;
    logic [VW-1:0]     dlv_vec;
    logic [DW-1:0]     dlv_dest;
    logic              dlv_logical;
    logic [NP-1:0]     coalesced, remote_pend;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    irq_pin_service #(.NPINS(NP), .VEC_W(VW), .DEST_W(DW), .BSP_DEST(BSP)) dut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .cfg_mask(cfg_mask),
        .cfg_pol(cfg_pol), .cfg_level(cfg_level), .cfg_logical(cfg_logical),
        .cfg_vec(cfg_vec), .cfg_dest(cfg_dest), .eoi_valid(eoi_valid),
        .eoi_vec(eoi_vec), .dlv_valid(dlv_valid), .dlv_pin(dlv_pin),
        .dlv_vec(dlv_vec), .dlv_dest(dlv_dest), .dlv_logical(dlv_logical),
        .coalesced(coalesced), .remote_pend(remote_pend)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pin_raw = '0; cfg_mask = '1; cfg_pol = '0; cfg_level = '0;
        cfg_logical = '0; cfg_vec = '0; cfg_dest = '0; eoi_valid = 1'b0; eoi_vec = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic set_pin(int i, logic m, logic p, logic lv, logic [7:0] v, logic [7:0] d, logic lg);
        cfg_mask[i] = m; cfg_pol[i] = p; cfg_level[i] = lv;
        cfg_vec[i*VW +: VW] = v; cfg_dest[i*DW +: DW] = d; cfg_logical[i] = lg;
    endtask

    task automatic send_eoi(logic [7:0] v);
        eoi_valid = 1'b1; eoi_vec = v;
        tick();
        eoi_valid = 1'b0;
    endtask

    task automatic chk_dlv(string tag, int p, logic [7:0] v);
        chk({tag, " valid"}, 32'(dlv_valid), 1);
        chk({tag, " pin"}, 32'(dlv_pin), 32'(p));
        chk({tag, " vec"}, 32'(dlv_vec), 32'(v));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R10: reset state
        chk("R10 reset dlv_valid", 32'(dlv_valid), 0);
        chk("R10 reset remote", 32'(remote_pend), 0);
        chk("R10 reset coalesced", 32'(coalesced), 0);

        // R1 R2 R8 R10: edge sweep over every line and both polarities
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < NP; i++) begin
                logic [7:0] v;
                logic [7:0] d;
                v = 8'h20 + 8'(i * 4 + p);
                d = 8'h10 + 8'(i);
                pin_raw[i] = p[0];
                set_pin(i, 1'b0, p[0], 1'b0, v, d, 1'b1);
                tick(); tick();
                chk("R1 inactive no dlv", 32'(dlv_valid), 0);
                for (int k = 0; k < 2; k++) begin
                    pin_raw[i] = ~p[0];
                    tick();
                    chk("R10 not yet", 32'(dlv_valid), 0);
                    tick();
                    chk_dlv("R2 edge dlv", i, v);
                    chk("R8 dest", 32'(dlv_dest), (i == 0) ? BSP : 32'(d));
                    chk("R8 mode", 32'(dlv_logical), (i == 0) ? 0 : 1);
                    for (int h = 0; h < 3; h++) begin
                        tick();
                        chk("R2 hold no dlv", 32'(dlv_valid), 0);
                    end
                    pin_raw[i] = p[0];
                    tick(); tick();
                    chk("R1 release no dlv", 32'(dlv_valid), 0);
                end
                cfg_mask[i] = 1'b1;
            end
        end

        // R5: masked edge and level lines
        do_reset();
        set_pin(2, 1'b1, 1'b0, 1'b0, 8'h33, 8'h02, 1'b0);
        set_pin(3, 1'b1, 1'b0, 1'b1, 8'h34, 8'h03, 1'b0);
        pin_raw[2] = 1'b1; pin_raw[3] = 1'b1;
        for (int h = 0; h < 4; h++) begin
            tick();
            chk("R5 masked no dlv", 32'(dlv_valid), 0);
            chk("R5 masked no remote", 32'(remote_pend), 0);
            chk("R5 masked no coalesced", 32'(coalesced), 0);
        end

        // R3 R4 R6 R7: single level line
        do_reset();
        set_pin(1, 1'b0, 1'b0, 1'b1, 8'h41, 8'h07, 1'b0);
        pin_raw[1] = 1'b1;
        tick();
        chk("R10 level not yet", 32'(dlv_valid), 0);
        tick();
        chk_dlv("R3 level dlv", 1, 8'h41);
        chk("R3 remote set", 32'(remote_pend), 32'h2);
        for (int h = 0; h < 3; h++) begin
            tick();
            chk("R3 gated no dlv", 32'(dlv_valid), 0);
            chk("R3 remote held", 32'(remote_pend), 32'h2);
        end
        pin_raw[1] = 1'b0; tick();
        pin_raw[1] = 1'b1; tick();
        chk("R4 level coalesced", 32'(coalesced), 32'h2);
        chk("R4 no dlv", 32'(dlv_valid), 0);
        tick();
        chk("R4 coalesced one cycle", 32'(coalesced), 0);
        send_eoi(8'h99);
        chk("R7 remote kept", 32'(remote_pend), 32'h2);
        chk("R7 no dlv", 32'(dlv_valid), 0);
        tick();
        chk("R7 still no dlv", 32'(dlv_valid), 0);
        chk("R7 remote still", 32'(remote_pend), 32'h2);
        send_eoi(8'h41);
        chk("R6 remote cleared", 32'(remote_pend), 0);
        tick();
        chk_dlv("R6 reissue", 1, 8'h41);
        chk("R6 remote again", 32'(remote_pend), 32'h2);
        pin_raw[1] = 1'b0;
        send_eoi(8'h41);
        chk("R6 released", 32'(remote_pend), 0);
        tick();
        chk("R6 inactive no reissue", 32'(dlv_valid), 0);
        chk("R6 stays clear", 32'(remote_pend), 0);

        // R6 R9: two level lines sharing one vector
        do_reset();
        set_pin(2, 1'b0, 1'b0, 1'b1, 8'h66, 8'h02, 1'b1);
        set_pin(3, 1'b0, 1'b0, 1'b1, 8'h66, 8'h03, 1'b1);
        pin_raw[2] = 1'b1; pin_raw[3] = 1'b1;
        tick();
        tick();
        chk_dlv("R9 shared first", 2, 8'h66);
        tick();
        chk_dlv("R9 shared second", 3, 8'h66);
        chk("R3 both remote", 32'(remote_pend), 32'hC);
        send_eoi(8'h66);
        chk("R6 both released", 32'(remote_pend), 0);
        tick();
        chk_dlv("R6 shared reissue a", 2, 8'h66);
        tick();
        chk_dlv("R6 shared reissue b", 3, 8'h66);
        chk("R6 both remote again", 32'(remote_pend), 32'hC);

        // R9 R4: all edge lines at once, last one toggled while queued
        do_reset();
        for (int i = 0; i < NP; i++)
            set_pin(i, 1'b0, 1'b0, 1'b0, 8'h80 + 8'(i), 8'h40 + 8'(i), 1'b1);
        pin_raw = '1;
        tick();
        chk("R10 burst not yet", 32'(dlv_valid), 0);
        tick();
        chk_dlv("R9 order 0", 0, 8'h80);
        pin_raw[3] = 1'b0;
        tick();
        chk_dlv("R9 order 1", 1, 8'h81);
        pin_raw[3] = 1'b1;
        tick();
        chk_dlv("R9 order 2", 2, 8'h82);
        chk("R4 edge coalesced", 32'(coalesced), 32'h8);
        tick();
        chk_dlv("R9 order 3", 3, 8'h83);
        chk("R4 edge coalesced once", 32'(coalesced), 0);
        tick();
        chk("R9 burst done", 32'(dlv_valid), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule